// File: doc/BRIEF.md
# Clock Periodic Event Generator

This block sits beside a running time-of-day and calendar counter and turns changes in the counter's fields into three sticky event flags. The flags are a once-per-second event, a time event and a calendar event. The time event fires on one of four conditions: a new minute, a new hour, the clock entering midnight, or the clock entering noon. The calendar event fires on one of three conditions: a week boundary, a new month or a new year. A fourth calendar selection turns the calendar event off.

Software programs the selections through a small register port. It reads the flags from a status register and clears them by writing ones to a clear-command register. Interrupt sources are switched on and off through separate enable and disable command registers, and a read-only mask register shows the current mask. A single interrupt line reports any flag whose mask bit is set.

The counter supplies binary field values and a one-cycle second tick. The block compares each field against its value from the previous cycle.

Top module: `cal_event_gen`

## Requirements
- R1: After reset the control register, the status register (address 1), the mask register (address 5) and `irq` all read 0. The time selection and the calendar selection are both 0.
- R2: A one-cycle `sec_tick` pulse sets status bit 2, which is the second flag. The flag can be read two rising edges after the tick is presented.
- R3: With time select 0 (control bits [1:0]), any change of `cur_min` sets status bit 3. With time select 1, any change of `cur_hour` sets it. Changes of other fields do not set it.
- R4: With time select 2, status bit 3 is set only when `cur_hour` becomes 0 from a non-zero value. With time select 3, it is set only when `cur_hour` becomes 12 from another value.
- R5: With calendar select 0 (control bits [3:2]), status bit 4 is set only when `cur_dow` goes from 7 to 1. Every other day-of-week step leaves it clear.
- R6: With calendar select 1, a change of `cur_month` sets status bit 4. With select 2, a change of `cur_year` sets it. With select 3, status bit 4 is never set.
- R7: Writing to the clear register (address 2) clears each status flag whose matching data bit (2, 3 or 4) is 1. Flags whose data bit is 0 keep their value.
- R8: Writing 1 to bit 2, 3 or 4 of the enable register (address 3) sets that mask bit. Writing 1 to the same bit of the disable register (address 4) clears it. Data bits written as 0 leave the mask unchanged. The mask reads back at address 5.
- R9: `irq` is high exactly when some status flag and its mask bit are both 1. It updates on the same edge as the status and mask registers.
- R10: When a flag's event and a clear of that flag happen on the same edge, the flag ends up set.
- R11: The first clock edge after reset only captures the counter fields and raises no event, even when those fields differ from zero.
- R12: Addresses 2, 3, 4, 6 and 7 read as 0. The control register reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for `rd_addr`, from registered state |
| sec_tick | input | 1 | One-cycle pulse at each new second |
| cur_min | input | 6 | Current minute, 0 to 59 |
| cur_hour | input | 5 | Current hour, 0 to 23 |
| cur_dow | input | 3 | Current day of week, 1 to 7 |
| cur_month | input | 4 | Current month, 1 to 12 |
| cur_year | input | 8 | Current year within the century |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the counter fields and `sec_tick` are synchronous to `clk`, that each field stays stable across the edge that samples it, and that `sec_tick` is a single-cycle pulse. Under those assumptions, comparing a field with its value from the previous cycle gives exactly one event per change. The stimulus drives every input on the falling edge and changes a single field per step, with one register write per cycle. This makes the expected flag after each step a plain function of the old value, the new value and the selection. The sweeps cover every hour and minute rollover under each time selection, and two full week cycles, a month wrap and several year changes under each calendar selection.

// File: rtl/cpeg_pkg.sv
package cpeg_pkg;
  typedef enum logic [1:0] {
    TSEL_MINUTE   = 2'd0,
    TSEL_HOUR     = 2'd1,
    TSEL_MIDNIGHT = 2'd2,
    TSEL_NOON     = 2'd3
  } tsel_e;

  typedef enum logic [1:0] {
    CSEL_WEEK  = 2'd0,
    CSEL_MONTH = 2'd1,
    CSEL_YEAR  = 2'd2,
    CSEL_OFF   = 2'd3
  } csel_e;

  // status, clear and mask registers share these bit positions
  localparam int FLAG_LSB = 2;
  localparam int FLAG_N   = 3;
  localparam int F_SEC    = 0;
  localparam int F_TIME   = 1;
  localparam int F_CAL    = 2;

  localparam int MAP_AW = 3;
  localparam logic [MAP_AW-1:0] A_CTRL = 3'd0;
  localparam logic [MAP_AW-1:0] A_STAT = 3'd1;
  localparam logic [MAP_AW-1:0] A_CLR  = 3'd2;
  localparam logic [MAP_AW-1:0] A_IEN  = 3'd3;
  localparam logic [MAP_AW-1:0] A_IDIS = 3'd4;
  localparam logic [MAP_AW-1:0] A_MASK = 3'd5;
endpackage

// File: rtl/cpeg_detect.sv
module cpeg_detect
  import cpeg_pkg::*;
#(
  parameter int MIN_W     = 6,
  parameter int HOUR_W    = 5,
  parameter int DOW_W     = 3,
  parameter int MON_W     = 4,
  parameter int YEAR_W    = 8,
  parameter int NOON_HOUR = 12,
  parameter int DOW_LAST  = 7,
  parameter int DOW_FIRST = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [YEAR_W-1:0] cur_year,
  input  tsel_e             tsel,
  input  csel_e             csel,
  output logic              sec_evt,
  output logic              time_evt,
  output logic              cal_evt
);
  localparam logic [HOUR_W-1:0] NOON_V  = HOUR_W'(NOON_HOUR);
  localparam logic [DOW_W-1:0]  DLAST_V = DOW_W'(DOW_LAST);
  localparam logic [DOW_W-1:0]  DFRST_V = DOW_W'(DOW_FIRST);

  logic              armed_q;
  logic [MIN_W-1:0]  min_q;
  logic [HOUR_W-1:0] hour_q;
  logic [DOW_W-1:0]  dow_q;
  logic [MON_W-1:0]  mon_q;
  logic [YEAR_W-1:0] year_q;
  logic              t_hit, c_hit;

  always_comb begin
    unique case (tsel)
      TSEL_MINUTE:   t_hit = (cur_min != min_q);
      TSEL_HOUR:     t_hit = (cur_hour != hour_q);
      TSEL_MIDNIGHT: t_hit = (cur_hour == '0) && (hour_q != '0);
      default:       t_hit = (cur_hour == NOON_V) && (hour_q != NOON_V);
    endcase
    unique case (csel)
      CSEL_WEEK:  c_hit = (dow_q == DLAST_V) && (cur_dow == DFRST_V);
      CSEL_MONTH: c_hit = (cur_month != mon_q);
      CSEL_YEAR:  c_hit = (cur_year != year_q);
      default:    c_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      min_q    <= '0;
      hour_q   <= '0;
      dow_q    <= '0;
      mon_q    <= '0;
      year_q   <= '0;
      sec_evt  <= 1'b0;
      time_evt <= 1'b0;
      cal_evt  <= 1'b0;
    end else begin
      armed_q  <= 1'b1;
      min_q    <= cur_min;
      hour_q   <= cur_hour;
      dow_q    <= cur_dow;
      mon_q    <= cur_month;
      year_q   <= cur_year;
      sec_evt  <= armed_q && sec_tick;
      time_evt <= armed_q && t_hit;
      cal_evt  <= armed_q && c_hit;
    end
  end

  assert_quiet_first_edge_R11: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !(sec_evt || time_evt || cal_evt));

  assert_week_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (cal_evt && $past(csel) == CSEL_WEEK) |-> $past(cur_dow) == DFRST_V);

  assert_noon_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (time_evt && $past(tsel) == TSEL_NOON) |-> $past(cur_hour) == NOON_V);
endmodule

// File: rtl/cpeg_regs.sv
module cpeg_regs
  import cpeg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sec_evt,
  input  logic              time_evt,
  input  logic              cal_evt,
  output tsel_e             tsel,
  output csel_e             csel,
  output logic              irq
);
  localparam int FLAG_MSB = FLAG_LSB + FLAG_N - 1;

  logic [DATA_W-1:0] ctrl_q;
  logic [FLAG_N-1:0] stat_q, stat_d, mask_q, mask_d;
  logic [FLAG_N-1:0] evt, clr_v, ien_v, idis_v, wsel;

  assign evt = {cal_evt, time_evt, sec_evt};
  assign wsel = wr_data[FLAG_MSB:FLAG_LSB];

  always_comb begin
    clr_v  = (wr_en && wr_addr == ADDR_W'(A_CLR))  ? wsel : '0;
    ien_v  = (wr_en && wr_addr == ADDR_W'(A_IEN))  ? wsel : '0;
    idis_v = (wr_en && wr_addr == ADDR_W'(A_IDIS)) ? wsel : '0;
    stat_d = (stat_q & ~clr_v) | evt;
    mask_d = (mask_q | ien_v) & ~idis_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_CTRL)) ctrl_q <= wr_data;
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & mask_d);
    end
  end

  assign tsel = tsel_e'(ctrl_q[1:0]);
  assign csel = csel_e'(ctrl_q[3:2]);

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(A_CTRL)) rd_data = ctrl_q;
    else if (rd_addr == ADDR_W'(A_STAT)) rd_data[FLAG_MSB:FLAG_LSB] = stat_q;
    else if (rd_addr == ADDR_W'(A_MASK)) rd_data[FLAG_MSB:FLAG_LSB] = mask_q;
  end

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_q & mask_q));

  assert_tick_sets_R2: assert property (@(posedge clk) disable iff (rst)
    sec_evt |=> stat_q[F_SEC]);

  for (genvar b = 0; b < FLAG_N; b++) begin : g_flag_chk
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      (evt[b] && clr_v[b]) |=> stat_q[b]);
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
      (clr_v[b] && !evt[b]) |=> !stat_q[b]);
    assert_enable_R8: assert property (@(posedge clk) disable iff (rst)
      ien_v[b] |=> mask_q[b]);
    assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
      idis_v[b] |=> !mask_q[b]);
  end
endmodule

// File: rtl/cal_event_gen.sv
module cal_event_gen
  import cpeg_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int MIN_W  = 6,
  parameter int HOUR_W = 5,
  parameter int DOW_W  = 3,
  parameter int MON_W  = 4,
  parameter int YEAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sec_tick,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DOW_W-1:0]  cur_dow,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [YEAR_W-1:0] cur_year,
  output logic              irq
);
  tsel_e tsel;
  csel_e csel;
  logic  sec_evt, time_evt, cal_evt;

  cpeg_detect #(
    .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DOW_W(DOW_W),
    .MON_W(MON_W), .YEAR_W(YEAR_W)
  ) u_detect (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_dow(cur_dow),
    .cur_month(cur_month), .cur_year(cur_year),
    .tsel(tsel), .csel(csel),
    .sec_evt(sec_evt), .time_evt(time_evt), .cal_evt(cal_evt)
  );

  cpeg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_evt(sec_evt), .time_evt(time_evt), .cal_evt(cal_evt),
    .tsel(tsel), .csel(csel), .irq(irq)
  );
endmodule

// File: tb/cal_event_gen_tb.sv
module cal_event_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sec_tick = 1'b0;
  logic [5:0] cur_min = 6'd30;
  logic [4:0] cur_hour = 5'd12;
  logic [2:0] cur_dow = 3'd7;
  logic [3:0] cur_month = 4'd5;
  logic [7:0] cur_year = 8'd24;
  logic       irq;
  int n_chk = 0, n_bad = 0, cyc = 0;

  cal_event_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sec_tick(sec_tick), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_dow(cur_dow), .cur_month(cur_month), .cur_year(cur_year),
    .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic apply(int m, int h, int d, int mo, int y);
    @(negedge clk);
    cur_min = 6'(m); cur_hour = 5'(h); cur_dow = 3'(d);
    cur_month = 4'(mo); cur_year = 8'(y);
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_t(int sel, int ph, int nh, int pm, int nm);
    case (sel)
      0: return pm != nm;
      1: return ph != nh;
      2: return nh == 0 && ph != 0;
      default: return nh == 12 && ph != 12;
    endcase
  endfunction

  function automatic logic exp_c(int sel, int pd, int nd, int pmo, int nmo, int py, int ny);
    case (sel)
      0: return pd == 7 && nd == 1;
      1: return pmo != nmo;
      2: return py != ny;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    int m, h, d, mo, y;
    int nm, nh, nd, nmo, ny;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state; R11 nonzero fields at reset raise nothing
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk("R11 status after reset", v, 8'h00);
    rd(3'd5, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    // R12 write-only and unused addresses read 0, ctrl read back
    for (int a = 2; a < 8; a++) begin
      if (a != 5) begin rd(3'(a), v); chk("R12 unmapped read", v, 8'h00); end
    end
    wr(3'd0, 8'hA3); rd(3'd0, v); chk("R12 ctrl readback", v, 8'hA3);

    m = 30; h = 12; d = 7; mo = 5; y = 24;
    // R3/R4 time sweep, calendar event off
    for (int sel = 0; sel < 4; sel++) begin
      wr(3'd0, 8'(sel | 12));
      wr(3'd2, 8'h1C);
      for (int s = 0; s < 84; s++) begin
        nh = (s < 24) ? (h + 1) % 24 : h;
        nm = (s < 24) ? m : (m + 1) % 60;
        apply(nm, nh, d, mo, y);
        rd(3'd1, v);
        chk(sel < 2 ? "R3 time event" : "R4 time event", v,
            8'(exp_t(sel, h, nh, m, nm)) << 3);
        h = nh; m = nm;
        wr(3'd2, 8'h08);
      end
    end
    // R5/R6 calendar sweep, time select minute with minute held
    for (int sel = 0; sel < 4; sel++) begin
      wr(3'd0, 8'(sel << 2));
      wr(3'd2, 8'h1C);
      for (int s = 0; s < 30; s++) begin
        nd = (s < 14) ? (d % 7) + 1 : d;
        nmo = (s >= 14 && s < 27) ? (mo % 12) + 1 : mo;
        ny = (s >= 27) ? y + 1 : y;
        apply(m, h, nd, nmo, ny);
        rd(3'd1, v);
        chk(sel == 0 ? "R5 week event" : "R6 calendar event", v,
            8'(exp_c(sel, d, nd, mo, nmo, y, ny)) << 4);
        d = nd; mo = nmo; y = ny;
        wr(3'd2, 8'h10);
      end
    end
    // R2 second tick
    wr(3'd0, 8'h0C);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    @(negedge clk);
    rd(3'd1, v); chk("R2 second flag", v, 8'h04);
    // R7 zero bits and other bits keep the flag
    wr(3'd2, 8'h00); rd(3'd1, v); chk("R7 write zero", v, 8'h04);
    wr(3'd2, 8'h18); rd(3'd1, v); chk("R7 other bits", v, 8'h04);
    // R9 irq follows mask
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h04); chk("R9 irq enabled", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h04); chk("R9 irq disabled", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'h04); rd(3'd1, v); chk("R7 clear", v, 8'h00);
    // R10 event and clear on the same edge
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0;
    rd(3'd1, v); chk("R10 set wins", v, 8'h04);
    wr(3'd2, 8'h04);
    // R8 mask enable and disable
    wr(3'd3, 8'h08); rd(3'd5, v); chk("R8 enable", v, 8'h08);
    wr(3'd3, 8'h00); rd(3'd5, v); chk("R8 enable zero", v, 8'h08);
    wr(3'd4, 8'h10); rd(3'd5, v); chk("R8 disable other", v, 8'h08);
    // R9 irq rises with the status flag
    apply((m + 1) % 60, h, d, mo, y);
    chk("R9 irq on event", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h08); rd(3'd5, v); chk("R8 disable", v, 8'h00);
    chk("R9 irq after disable", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h1C); rd(3'd5, v); chk("R8 enable all", v, 8'h1C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule